// File: doc/BRIEF.md
# Multiplexed Bus Request Decoder

This block sits on the target side of a processor's external bus, for example in a memory controller. It captures requests that the processor sends over a narrow multiplexed request bus. Each request takes two consecutive cycles of the bus clock. In the first cycle, an active-low start strobe opens the request, and the same cycle carries the direction, an atomic-lock flag and the upper half of the address. In the second cycle, the three control pins are reused to carry a 3-bit transfer length, and the address pins carry the lower half of the address.

The decoder tracks which of the two cycles is on the wire. It rebuilds a 32-bit request from the two halves and appends that request to a small queue. The queue feeds a valid/ready output port. When the processor has been granted hold mode, it has floated its request pins, so any strobe seen in that state is ignored. If a request finishes while the queue is full, that request is dropped and an error pulse is raised.

Top module: `mux_req_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the decoder returns to the idle phase and the queue empties. After that edge, `out_valid` and `overflow_err` are both 0.
- R2: In the idle phase, `start_n` = 0 with `hold_granted` = 0 at an edge starts a request. At that edge the decoder captures `addr_half` as address bits 31:16, `dir_len0` as the direction (1 = write, 0 = read) and `lock_len1` as the atomic-lock flag.
- R3: The edge that follows a detected start is always the second phase, whatever level `start_n` has at that edge. At the second-phase edge, the length is taken as {`start_n`, `lock_len1`, `dir_len0`} (bit 2 down to bit 0), and `addr_half` is taken as address bits 15:0.
- R4: A decoded request is visible on the output port right after its second-phase edge. The output fields are `out_addr`, `out_write`, `out_lock` and `out_len`.
- R5: A start strobe sampled while `hold_granted` is 1 in the idle phase has no effect: no request is queued and the phase stays idle.
- R6: The queue holds `FIFO_DEPTH` (default 4) requests and returns them in arrival order. The head entry is popped at an edge where `out_valid` and `out_ready` are both 1.
- R7: A request that completes while the queue is full is dropped, and the queued entries are left unchanged. `overflow_err` is 1 for exactly the one cycle after the dropping edge.
- R8: A new start is accepted at the edge right after a second phase, so back-to-back requests are each decoded.
- R9: While `out_valid` is 1 and `out_ready` is 0, the output fields stay stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; everything is sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hold_granted | input | 1 | Processor has entered hold mode and floated its request pins |
| start_n | input | 1 | Phase 1: active-low start strobe; phase 2: length bit 2 |
| lock_len1 | input | 1 | Phase 1: atomic-lock flag; phase 2: length bit 1 |
| dir_len0 | input | 1 | Phase 1: write (1) / read (0); phase 2: length bit 0 |
| addr_half | input | 16 | Phase 1: address bits 31:16; phase 2: address bits 15:0 |
| out_ready | input | 1 | Consumer accepts the head request |
| out_valid | output | 1 | A decoded request is at the head of the queue |
| out_addr | output | 32 | Full request address |
| out_write | output | 1 | Request direction, 1 = write |
| out_lock | output | 1 | Request is half of an atomic read-write pair |
| out_len | output | 3 | Transfer length code |
| overflow_err | output | 1 | One-cycle pulse: a request was dropped because the queue was full |

## Verification
A request shows up on the output port right after the second sampling edge of its issue. So the bench drives each pin set on a falling edge and reads the port on the falling edge that follows the second rising edge. The overflow pulse is also due right after the dropping edge, and the bench checks it there. One cycle later it checks that the pulse has cleared. A pop takes effect at the single rising edge during which `out_ready` is held high, and the next head is read on the falling edge after that. The bench sweeps every combination of length, direction and lock, with addresses computed arithmetically. It also covers the hold, back-to-back, full-queue and mid-request reset cases.

// File: rtl/mrd_pkg.sv
package mrd_pkg;

    localparam int HALF_W = 16;
    localparam int ADDR_W = 2 * HALF_W;
    localparam int LEN_W  = 3;

    typedef enum logic {
        PH_IDLE   = 1'b0,
        PH_SECOND = 1'b1
    } phase_e;

    // Fields latched during the first issue cycle.
    typedef struct packed {
        logic [HALF_W-1:0] upper;
        logic              write;
        logic              lock;
    } head_t;

    // Complete decoded request as held in the queue.
    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        logic              write;
        logic              lock;
        logic [LEN_W-1:0]  len;
    } req_t;

    // Merge the first-cycle head with the pins seen in the second cycle.
    function automatic req_t build_req(
        input head_t             head,
        input logic [HALF_W-1:0] lower,
        input logic              len_hi,
        input logic              len_mid,
        input logic              len_lo
    );
        req_t r;
        r.addr  = {head.upper, lower};
        r.write = head.write;
        r.lock  = head.lock;
        r.len   = {len_hi, len_mid, len_lo};
        return r;
    endfunction

endpackage

// File: rtl/issue_tracker.sv
module issue_tracker
    import mrd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_granted,
    input  logic              start_n,
    input  logic              lock_len1,
    input  logic              dir_len0,
    input  logic [HALF_W-1:0] addr_half,
    output logic              push,
    output req_t              push_req
);

    phase_e phase_q;
    head_t  head_q;
    logic   start_seen;

    assign start_seen = (phase_q == PH_IDLE) && !start_n && !hold_granted;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            head_q  <= '0;
        end else begin
            unique case (phase_q)
                PH_IDLE: begin
                    if (start_seen) begin
                        phase_q      <= PH_SECOND;
                        head_q.upper <= addr_half;
                        head_q.write <= dir_len0;
                        head_q.lock  <= lock_len1;
                    end
                end
                PH_SECOND: phase_q <= PH_IDLE;
                default:   phase_q <= PH_IDLE;
            endcase
        end
    end

    assign push     = (phase_q == PH_SECOND);
    assign push_req = build_req(head_q, addr_half, start_n, lock_len1, dir_len0);

    // R2: a start opens the second phase and latches the upper half
    assert_start_opens_R2: assert property (@(posedge clk) disable iff (rst)
        ((phase_q == PH_IDLE) && !start_n && !hold_granted)
        |=> ((phase_q == PH_SECOND) && (head_q.upper == $past(addr_half))));

    // R3/R8: the second phase lasts exactly one cycle
    assert_second_once_R3: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_SECOND) |=> (phase_q == PH_IDLE));

    // R5: strobes under hold leave the tracker idle
    assert_hold_ignores_R5: assert property (@(posedge clk) disable iff (rst)
        ((phase_q == PH_IDLE) && hold_granted) |=> (phase_q == PH_IDLE));

endmodule

// File: rtl/req_fifo.sv
module req_fifo
    import mrd_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic push,
    input  req_t push_req,
    input  logic pop_ready,
    output logic out_valid,
    output req_t out_req,
    output logic overflow
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    req_t             mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0] count_q;
    logic             ovf_q;
    logic             full, do_push, do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full      = (count_q == CNT_W'(DEPTH));
    assign out_valid = (count_q != '0);
    assign do_pop    = out_valid && pop_ready;
    assign do_push   = push && !full;
    assign out_req   = mem[rd_ptr_q];
    assign overflow  = ovf_q;

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr_q] <= push_req;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
            ovf_q    <= 1'b0;
        end else begin
            ovf_q <= push && full;
            if (do_push) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (do_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
            unique case ({do_push, do_pop})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // R6: occupancy never passes the depth
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (rst)
        count_q <= CNT_W'(DEPTH));

    // R7: the error pulse follows only a push into a full queue
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
        ovf_q |-> $past(push && full));

    // R7: a dropped request leaves the occupancy unchanged
    assert_drop_keeps_R7: assert property (@(posedge clk) disable iff (rst)
        (push && full && !do_pop) |=> (count_q == $past(count_q)));

    // R9: a stalled head stays put
    assert_head_stable_R9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !pop_ready) |=> (out_valid && $stable(out_req)));

endmodule

// File: rtl/mux_req_decoder.sv
module mux_req_decoder
    import mrd_pkg::*;
#(
    parameter int FIFO_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_granted,
    input  logic              start_n,
    input  logic              lock_len1,
    input  logic              dir_len0,
    input  logic [HALF_W-1:0] addr_half,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [ADDR_W-1:0] out_addr,
    output logic              out_write,
    output logic              out_lock,
    output logic [LEN_W-1:0]  out_len,
    output logic              overflow_err
);

    logic push;
    req_t push_req;
    req_t head_req;

    issue_tracker u_tracker (
        .clk          (clk),
        .rst          (rst),
        .hold_granted (hold_granted),
        .start_n      (start_n),
        .lock_len1    (lock_len1),
        .dir_len0     (dir_len0),
        .addr_half    (addr_half),
        .push         (push),
        .push_req     (push_req)
    );

    req_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_req  (push_req),
        .pop_ready (out_ready),
        .out_valid (out_valid),
        .out_req   (head_req),
        .overflow  (overflow_err)
    );

    assign out_addr  = head_req.addr;
    assign out_write = head_req.write;
    assign out_lock  = head_req.lock;
    assign out_len   = head_req.len;

endmodule

// File: tb/tb_mux_req_decoder.sv
module tb_mux_req_decoder;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        hold_granted = 1'b0;
    logic        start_n = 1'b1;
    logic        lock_len1 = 1'b0;
    logic        dir_len0 = 1'b0;
    logic [15:0] addr_half = '0;
    logic        out_ready = 1'b0;
    logic        out_valid;
    logic [31:0] out_addr;
    logic        out_write, out_lock;
    logic [2:0]  out_len;
    logic        overflow_err;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    mux_req_decoder dut (
        .clk(clk), .rst(rst), .hold_granted(hold_granted),
        .start_n(start_n), .lock_len1(lock_len1), .dir_len0(dir_len0),
        .addr_half(addr_half), .out_ready(out_ready), .out_valid(out_valid),
        .out_addr(out_addr), .out_write(out_write), .out_lock(out_lock),
        .out_len(out_len), .overflow_err(overflow_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [37:0] pack(input logic [31:0] a, input logic w, input logic l, input logic [2:0] n);
        return {a, w, l, n};
    endfunction

    // Two issue cycles, each driven on a falling edge.
    task automatic issue(input logic [31:0] a, input logic w, input logic l, input logic [2:0] n);
        @(negedge clk);
        start_n = 1'b0; lock_len1 = l; dir_len0 = w; addr_half = a[31:16];
        @(negedge clk);
        start_n = n[2]; lock_len1 = n[1]; dir_len0 = n[0]; addr_half = a[15:0];
    endtask

    task automatic idle();
        @(negedge clk);
        start_n = 1'b1; lock_len1 = 1'b0; dir_len0 = 1'b0; addr_half = 16'hFFFF;
    endtask

    task automatic head_is(input logic [37:0] exp, input string tag);
        logic [37:0] act;
        act = pack(out_addr, out_write, out_lock, out_len);
        chk(out_valid === 1'b1, {tag, " valid"}, 64'(out_valid), 64'd1);
        chk(act === exp, {tag, " fields"}, 64'(act), 64'(exp));
    endtask

    task automatic pop();
        @(negedge clk);
        out_ready = 1'b1;
        @(negedge clk);
        out_ready = 1'b0;
    endtask

    function automatic logic [31:0] addr_of(input int k);
        return 32'(32'h9E37_79B9 * (k + 1)) ^ 32'h0F0F_0000;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        chk(out_valid === 1'b0, "R1 valid after reset", 64'(out_valid), 64'd0);
        chk(overflow_err === 1'b0, "R1 overflow after reset", 64'(overflow_err), 64'd0);

        // R2 R3 R4: sweep every length/direction/lock combination
        for (int k = 0; k < 32; k++) begin
            logic [37:0] e;
            e = pack(addr_of(k), k[3], k[4], k[2:0]);
            issue(addr_of(k), k[3], k[4], k[2:0]);
            idle();
            head_is(e, "R2 R3 R4 sweep");
            pop();
            chk(out_valid === 1'b0, "R6 empty after pop", 64'(out_valid), 64'd0);
        end

        // R5: strobe under hold is ignored, also on the following cycle
        hold_granted = 1'b1;
        issue(32'h1234_5678, 1'b1, 1'b1, 3'b000);
        idle();
        idle();
        chk(out_valid === 1'b0, "R5 no request under hold", 64'(out_valid), 64'd0);
        hold_granted = 1'b0;
        issue(32'hCAFE_0042, 1'b0, 1'b1, 3'b101);
        idle();
        head_is(pack(32'hCAFE_0042, 1'b0, 1'b1, 3'b101), "R5 decode after hold");
        pop();

        // R8 R6 R7 R9: back-to-back fill, overflow, ordering
        for (int k = 0; k < 5; k++) issue(addr_of(40 + k), k[0], k[1], 3'(k + 2));
        idle();
        chk(overflow_err === 1'b1, "R7 overflow pulse", 64'(overflow_err), 64'd1);
        idle();
        chk(overflow_err === 1'b0, "R7 pulse lasts one cycle", 64'(overflow_err), 64'd0);
        idle();
        idle();
        head_is(pack(addr_of(40), 1'b0, 1'b0, 3'd2), "R9 stalled head");
        for (int k = 0; k < 4; k++) begin
            logic [2:0] n;
            n = 3'(k + 2);
            head_is(pack(addr_of(40 + k), k[0], k[1], n), "R6 R8 order");
            pop();
        end
        chk(out_valid === 1'b0, "R7 dropped request absent", 64'(out_valid), 64'd0);

        // R1: reset during a request, with one entry queued
        issue(32'hAAAA_5555, 1'b1, 1'b0, 3'b011);
        idle();
        @(negedge clk);
        start_n = 1'b0; addr_half = 16'h7777;
        @(negedge clk);
        rst = 1'b1; start_n = 1'b1; addr_half = 16'h8888;
        @(negedge clk);
        rst = 1'b0;
        chk(out_valid === 1'b0, "R1 reset empties queue", 64'(out_valid), 64'd0);
        idle();
        chk(out_valid === 1'b0, "R1 no ghost second phase", 64'(out_valid), 64'd0);
        issue(32'h0BAD_F00D, 1'b1, 1'b1, 3'b111);
        idle();
        head_is(pack(32'h0BAD_F00D, 1'b1, 1'b1, 3'b111), "R1 decode after reset");
        pop();

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule